// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block holds the host-visible control state for one channel of a bus-mastering disk DMA engine: a command byte, a status byte and a 32-bit descriptor-table base pointer. The host reaches them through a byte-addressed port that takes accesses of 1, 2 or 4 bytes at any offset. The block splits each access into single-byte operations, one for each covered offset, and routes them to the registers.

The block watches for edges on the run bit of the command byte. Start and stop take effect only when that bit changes. A stop emits a one-cycle cancel pulse toward the drive logic. A start copies the base pointer into a working pointer for the descriptor walker and emits a one-cycle start pulse. From the drive side, an error pulse and an interrupt level set sticky status flags, which the host clears by writing ones. The interrupt level also passes straight through to the host interrupt line. The walker can drop the active flag when a transfer ends.

Top module: `dma_ctl_regs`

## Requirements
- R1: The command byte sits at offset 0 and keeps only bit 0 (run) and bit 3 (direction, also on `dir_o`). All other written bits read back as 0.
- R2: A command write whose run bit equals the stored run bit produces no start pulse, no cancel pulse and no reload of the working pointer.
- R3: A run-bit change from 1 to 0 raises `cancel_o` for exactly the cycle after the write and clears the active flag (status bit 0).
- R4: A run-bit change from 0 to 1 loads the working pointer with the base pointer as it stood before that write. If the active flag was clear, the same write sets it and raises `start_o` for the cycle after the write.
- R5: Status sits at offset 2. Written bits 6 and 5 are stored as written. Bit 0 (active) ignores host writes. Bits 1 (error) and 2 (interrupt) clear when written with 1 and keep their value when written with 0. Bits 7, 4 and 3 read as 0.
- R6: `host_irq_o` follows `drv_irq_i` with no delay. A 0-to-1 change of `drv_irq_i` sets status bit 2. A 1-to-0 change leaves status unchanged. A `drv_err_i` pulse sets status bit 1.
- R7: The base pointer sits at offsets 4 to 7, least significant byte first. Each covered byte lane updates independently, and bits 1:0 always read 0.
- R8: While `rst_ni` is low, command, status, base pointer, working pointer and both pulses read 0, and any active transfer is dropped.
- R9: An access covers offsets `addr_i` to `addr_i`+n-1, where n is 1, 2 or 4 for `size_i` = 0, 1 or 2 (3 acts as 4). Data byte k maps to offset `addr_i`+k. Offsets 1, 3 and any offset beyond 7 read 0 and ignore writes, and read lanes beyond n read 0.
- R10: When a drive event and a host write-one-to-clear of the same status flag fall in one cycle, the flag ends up set.
- R11: `active_clr_i` clears the active flag without changing the command byte. A 0-to-1 run write in the same cycle takes priority and leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for the current access |
| addr_i | input | 3 | Byte offset of the first byte accessed |
| size_i | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| wdata_i | input | 32 | Write data, byte k goes to offset addr_i+k |
| rdata_o | output | 32 | Read data for the current access (combinational) |
| start_o | output | 1 | One-cycle pulse that starts the transfer |
| cancel_o | output | 1 | One-cycle pulse that cancels the transfer |
| active_o | output | 1 | Active flag (status bit 0) |
| active_clr_i | input | 1 | Walker request to clear the active flag |
| dir_o | output | 1 | Direction bit of the command byte |
| base_ptr_o | output | 32 | Descriptor-table base pointer |
| work_ptr_o | output | 32 | Working table pointer loaded on start |
| drv_irq_i | input | 1 | Drive interrupt level |
| drv_err_i | input | 1 | Drive error event pulse |
| host_irq_o | output | 1 | Interrupt line to the host |

## Verification
Two collisions are forced on purpose. In the first, the bench raises `drv_irq_i` on the same clock edge as a status write that has ones in both the error and interrupt positions. The next status read must show the error flag cleared and the interrupt flag still set. In the second, a stop-then-start sequence on the run bit is issued with `active_clr_i` high in the cycle of the start write. The bench expects a start pulse and the active flag to stay set. All outcomes are checked through the register port and the pulse outputs.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
  localparam int unsigned OFF_CMD  = 0;
  localparam int unsigned OFF_STAT = 2;
  localparam int unsigned OFF_PTR  = 4;

  localparam int unsigned CMD_RUN = 0;
  localparam int unsigned CMD_DIR = 3;
  localparam logic [7:0]  CMD_KEEP = 8'h09;

  localparam int unsigned ST_ACT = 0;
  localparam int unsigned ST_ERR = 1;
  localparam int unsigned ST_INT = 2;
  localparam logic [7:0]  ST_RW  = 8'h60;

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_W2 = 2'd3} size_e;
endpackage

// File: rtl/dmareg_lane_dec.sv
module dmareg_lane_dec #(
  parameter int unsigned NOFF = 8,
  parameter int unsigned DB   = 4,
  localparam int unsigned AW  = $clog2(NOFF),
  localparam int unsigned LW  = $clog2(DB)
) (
  input  logic                     wr_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [AW:0]              nb_i,
  input  logic [DB*8-1:0]          wdata_i,
  output logic [NOFF-1:0]          byte_we_o,
  output logic [NOFF-1:0][7:0]     byte_wd_o
);
  for (genvar o = 0; o < NOFF; o++) begin : g_off
    logic [AW:0] rel;
    always_comb begin
      rel          = (AW+1)'(o) - {1'b0, addr_i};
      byte_we_o[o] = wr_i && ((AW+1)'(o) >= {1'b0, addr_i}) && (rel < nb_i);
      byte_wd_o[o] = wdata_i[{rel[LW-1:0], 3'b000} +: 8];
    end
  end
endmodule

// File: rtl/dmareg_ptr.sv
module dmareg_ptr #(
  parameter int unsigned PB = 4,
  localparam int unsigned PW = PB*8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PB-1:0]      byte_we_i,
  input  logic [PB-1:0][7:0] byte_wd_i,
  input  logic               load_work_i,
  output logic [PW-1:0]      base_o,
  output logic [PW-1:0]      work_o
);
  logic [PB-1:0][7:0] base_q, base_n;

  always_comb begin
    base_n = base_q;
    for (int l = 0; l < PB; l++)
      if (byte_we_i[l]) base_n[l] = byte_wd_i[l];
    base_n[0][1:0] = 2'b00;  // dword alignment
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      work_o <= '0;
    end else begin
      base_q <= base_n;
      if (load_work_i) work_o <= base_q;
    end
  end

  assign base_o = base_q;

  p_work_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_work_i |=> work_o == $past(base_o));
  p_ptr_lane_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_we_i[PB-1] |=> base_o[PW-1 -: 8] == $past(byte_wd_i[PB-1]));
  p_ptr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_we_i == '0) |=> $stable(base_o));
endmodule

// File: rtl/dmareg_ctl.sv
module dmareg_ctl
  import dmareg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_we_i,
  input  logic [7:0] cmd_wd_i,
  input  logic       st_we_i,
  input  logic [7:0] st_wd_i,
  input  logic       active_clr_i,
  input  logic       drv_irq_i,
  input  logic       drv_err_i,
  output logic [7:0] cmd_o,
  output logic [7:0] stat_o,
  output logic       start_o,
  output logic       cancel_o,
  output logic       load_work_o
);
  logic [7:0] cmd_q;
  logic       act_q, err_q, int_q, irq_q;
  logic [1:0] rw_q;
  logic       run_chg, go, halt, irq_rise;
  logic       act_n, err_n, int_n;

  always_comb begin
    run_chg  = cmd_we_i && (cmd_wd_i[CMD_RUN] != cmd_q[CMD_RUN]);
    go       = run_chg && cmd_wd_i[CMD_RUN];
    halt     = run_chg && !cmd_wd_i[CMD_RUN];
    irq_rise = drv_irq_i && !irq_q;

    act_n = act_q;
    if (active_clr_i || halt) act_n = 1'b0;
    if (go)                   act_n = 1'b1;

    // drive events win over host clears in the same cycle
    err_n = err_q;
    if (st_we_i && st_wd_i[ST_ERR]) err_n = 1'b0;
    if (drv_err_i)                  err_n = 1'b1;
    int_n = int_q;
    if (st_we_i && st_wd_i[ST_INT]) int_n = 1'b0;
    if (irq_rise)                   int_n = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= '0;
      act_q    <= 1'b0;
      err_q    <= 1'b0;
      int_q    <= 1'b0;
      irq_q    <= 1'b0;
      rw_q     <= '0;
      start_o  <= 1'b0;
      cancel_o <= 1'b0;
    end else begin
      if (cmd_we_i) cmd_q <= cmd_wd_i & CMD_KEEP;
      if (st_we_i)  rw_q  <= st_wd_i[6:5];
      act_q    <= act_n;
      err_q    <= err_n;
      int_q    <= int_n;
      irq_q    <= drv_irq_i;
      start_o  <= go && !act_q;
      cancel_o <= halt;
    end
  end

  assign cmd_o       = cmd_q;
  assign stat_o      = {1'b0, rw_q, 2'b00, int_q, err_q, act_q};
  assign load_work_o = go;

  p_same_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_wd_i[CMD_RUN] == cmd_o[CMD_RUN]) |=> !start_o && !cancel_o);
  p_cancel_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_o |-> !stat_o[ST_ACT]);
  p_start_active_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> stat_o[ST_ACT] && !cancel_o);
  p_act_ro_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_we_i && !cmd_we_i && !active_clr_i) |=> $stable(stat_o[ST_ACT]));
  p_irq_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_irq_i) |=> stat_o[ST_INT]);
  p_err_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_err_i |=> stat_o[ST_ERR]);
  p_clr_act_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_clr_i && !cmd_we_i) |=> !stat_o[ST_ACT]);
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dmareg_pkg::*;
#(
  parameter int unsigned DATA_BYTES = 4,
  parameter int unsigned PTR_BYTES  = 4,
  localparam int unsigned NOFF = OFF_PTR + PTR_BYTES,
  localparam int unsigned AW   = $clog2(NOFF),
  localparam int unsigned DW   = DATA_BYTES*8,
  localparam int unsigned PW   = PTR_BYTES*8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          start_o,
  output logic          cancel_o,
  output logic          active_o,
  input  logic          active_clr_i,
  output logic          dir_o,
  output logic [PW-1:0] base_ptr_o,
  output logic [PW-1:0] work_ptr_o,
  input  logic          drv_irq_i,
  input  logic          drv_err_i,
  output logic          host_irq_o
);
  logic [AW:0]           nb;
  logic [NOFF-1:0]       byte_we;
  logic [NOFF-1:0][7:0]  byte_wd;
  logic [NOFF-1:0][7:0]  regb;
  logic [7:0]            cmd, stat;
  logic                  load_work;

  always_comb begin
    unique case (size_e'(size_i))
      SZ_B:    nb = (AW+1)'(1);
      SZ_H:    nb = (AW+1)'(2);
      default: nb = (AW+1)'(DATA_BYTES);
    endcase
  end

  dmareg_lane_dec #(.NOFF(NOFF), .DB(DATA_BYTES)) u_dec (
    .wr_i(wr_i), .addr_i(addr_i), .nb_i(nb), .wdata_i(wdata_i),
    .byte_we_o(byte_we), .byte_wd_o(byte_wd)
  );

  dmareg_ctl u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cmd_we_i(byte_we[OFF_CMD]), .cmd_wd_i(byte_wd[OFF_CMD]),
    .st_we_i(byte_we[OFF_STAT]), .st_wd_i(byte_wd[OFF_STAT]),
    .active_clr_i(active_clr_i), .drv_irq_i(drv_irq_i), .drv_err_i(drv_err_i),
    .cmd_o(cmd), .stat_o(stat), .start_o(start_o), .cancel_o(cancel_o),
    .load_work_o(load_work)
  );

  dmareg_ptr #(.PB(PTR_BYTES)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .byte_we_i(byte_we[OFF_PTR +: PTR_BYTES]),
    .byte_wd_i(byte_wd[OFF_PTR +: PTR_BYTES]),
    .load_work_i(load_work), .base_o(base_ptr_o), .work_o(work_ptr_o)
  );

  always_comb begin
    regb           = '0;
    regb[OFF_CMD]  = cmd;
    regb[OFF_STAT] = stat;
    regb[OFF_PTR +: PTR_BYTES] = base_ptr_o;
  end

  for (genvar k = 0; k < DATA_BYTES; k++) begin : g_rd
    logic [AW:0] off;
    logic        hit;
    always_comb begin
      off = {1'b0, addr_i} + (AW+1)'(k);
      hit = ((AW+1)'(k) < nb) && (off < (AW+1)'(NOFF));
      rdata_o[k*8 +: 8] = hit ? regb[off[AW-1:0]] : 8'h00;
    end
  end

  assign active_o   = stat[ST_ACT];
  assign dir_o      = cmd[CMD_DIR];
  assign host_irq_o = drv_irq_i;

  p_host_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_irq_o == drv_irq_i);
  p_start_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> work_ptr_o == $past(base_ptr_o));
  p_no_collide_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && cancel_o));
endmodule

// File: tb/dma_ctl_regs_tb_top.sv
module dma_ctl_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int K_RD = 0, K_START = 1, K_CANCEL = 2, K_ACT = 3,
                 K_HIRQ = 4, K_WORK = 5, K_DIR = 6;

  typedef struct {
    int          due;
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o, base_ptr_o, work_ptr_o;
  logic        start_o, cancel_o, active_o, dir_o, host_irq_o;
  logic        active_clr_i = 1'b0, drv_irq_i = 1'b0, drv_err_i = 1'b0;

  int    cyc = 0, n_chk = 0, n_fail = 0;
  bit    done = 1'b0;
  item_t sb[$];

  dma_ctl_regs dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i), .size_i(size_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .start_o(start_o), .cancel_o(cancel_o),
    .active_o(active_o), .active_clr_i(active_clr_i), .dir_o(dir_o),
    .base_ptr_o(base_ptr_o), .work_ptr_o(work_ptr_o), .drv_irq_i(drv_irq_i),
    .drv_err_i(drv_err_i), .host_irq_o(host_irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] got(int kind);
    case (kind)
      K_RD:     return rdata_o;
      K_START:  return 32'(start_o);
      K_CANCEL: return 32'(cancel_o);
      K_ACT:    return 32'(active_o);
      K_HIRQ:   return 32'(host_irq_o);
      K_WORK:   return work_ptr_o;
      default:  return 32'(dir_o);
    endcase
  endfunction

  task automatic push(int kind, logic [31:0] exp, string req, int dly);
    item_t it;
    it.due = cyc + dly; it.kind = kind; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  // monitor: pop items that fall due, compare against live outputs
  initial forever begin
    @(negedge clk); #1;
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        logic [31:0] g;
        g = got(sb[i].kind);
        n_chk++;
        if (g !== sb[i].exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", sb[i].req, sb[i].kind, g, sb[i].exp);
        end
        sb.delete(i);
      end
    end
  end

  task automatic wr(logic [2:0] a, logic [1:0] s, logic [31:0] d);
    wr_i = 1'b1; addr_i = a; size_i = s; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [1:0] s, logic [31:0] exp, string req);
    wr_i = 1'b0; addr_i = a; size_i = s;
    push(K_RD, exp, req, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    push(K_ACT, 0, "R8", 0); push(K_WORK, 0, "R8", 0);
    rst_ni = 1'b1;
    rd(0, 2, 32'h0, "R8");
    rd(4, 2, 32'h0, "R8");
    // pointer lanes
    wr(4, 2, 32'h1234_5677);
    rd(4, 2, 32'h1234_5674, "R7");
    wr(5, 0, 32'h0000_00AB);
    wr(6, 1, 32'h0000_BEEF);
    wr(4, 0, 32'h0000_00FF);
    rd(4, 2, 32'hBEEF_ABFC, "R7");
    rd(6, 1, 32'h0000_BEEF, "R9");
    rd(7, 2, 32'h0000_00BE, "R9");
    wr(1, 0, 32'h0000_00FF);
    rd(1, 0, 32'h0, "R9");
    rd(3, 0, 32'h0, "R9");
    // start
    push(K_START, 1, "R4", 1); push(K_WORK, 32'hBEEF_ABFC, "R4", 1);
    push(K_ACT, 1, "R4", 1);   push(K_DIR, 1, "R1", 1);
    wr(0, 0, 32'h0000_00FF);
    rd(0, 0, 32'h09, "R1");
    rd(2, 0, 32'h01, "R4");
    // unchanged run bit
    wr(4, 2, 32'h0000_1000);
    push(K_START, 0, "R2", 1); push(K_CANCEL, 0, "R2", 1);
    push(K_WORK, 32'hBEEF_ABFC, "R2", 1); push(K_DIR, 0, "R1", 1);
    wr(0, 0, 32'h01);
    rd(0, 0, 32'h01, "R2");
    // status rw bits, active read-only
    wr(2, 0, 32'h67);
    rd(2, 0, 32'h61, "R5");
    // drive events
    drv_err_i = 1'b1; @(negedge clk); drv_err_i = 1'b0;
    rd(2, 0, 32'h63, "R6");
    drv_irq_i = 1'b1; push(K_HIRQ, 1, "R6", 0); @(negedge clk);
    rd(2, 0, 32'h67, "R6");
    drv_irq_i = 1'b0; push(K_HIRQ, 0, "R6", 0); @(negedge clk);
    rd(2, 0, 32'h67, "R6");
    // write-one-to-clear
    wr(2, 0, 32'h04);
    rd(2, 0, 32'h03, "R5");
    // collision: irq rise with W1C of err and int
    drv_irq_i = 1'b1;
    wr(2, 0, 32'h06);
    rd(2, 0, 32'h05, "R10");
    drv_irq_i = 1'b0; @(negedge clk);
    // stop
    push(K_CANCEL, 1, "R3", 1); push(K_START, 0, "R3", 1); push(K_ACT, 0, "R3", 1);
    wr(0, 0, 32'h00);
    rd(2, 0, 32'h04, "R3");
    // restart then walker clears active
    push(K_START, 1, "R4", 1); push(K_WORK, 32'h0000_1000, "R4", 1);
    wr(0, 0, 32'h01);
    active_clr_i = 1'b1; push(K_ACT, 0, "R11", 1); @(negedge clk); active_clr_i = 1'b0;
    rd(0, 0, 32'h01, "R11");
    rd(2, 0, 32'h04, "R11");
    push(K_START, 0, "R2", 1); push(K_ACT, 0, "R2", 1);
    wr(0, 0, 32'h01);
    // collision: start write with walker clear
    wr(0, 0, 32'h00);
    active_clr_i = 1'b1;
    push(K_START, 1, "R11", 1); push(K_ACT, 1, "R11", 1);
    wr(0, 0, 32'h01);
    active_clr_i = 1'b0;
    rd(2, 0, 32'h05, "R11");
    // reset mid-run
    rst_ni = 1'b0;
    rd(0, 2, 32'h0, "R8");
    push(K_ACT, 0, "R8", 0); push(K_WORK, 0, "R8", 0);
    rd(4, 2, 32'h0, "R8");
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    if (sb.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", sb.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule